// File: doc/BRIEF.md
# Serial ADC Output Sequencer

This block models the digital side of a sampling converter that reports each result over a three-wire serial port. It runs on a fast system clock. It watches an active-low chip-select and a slower serial clock as ordinary synchronous inputs, and it treats each falling edge of the serial clock as one bit period. It drives a serial data line together with a separate enable, so a tri-state pad can sit outside the block.

A conversion frame begins when chip-select is seen high and then low. The first falling serial-clock edge is the sampling period, and the line stays released through it. The second falling edge latches the parallel sample word and drives a low null bit. The word then follows, most significant bit first. A mode input is captured when chip-select falls and selects the tail of the frame:
- **Mirror mode:** the word is sent again from bit 1 up to the top bit, and then the line is released.
- **Fill mode:** zeros are driven for as long as chip-select stays low.

Raising chip-select releases the line at any point in the frame.

Top module: `serial_adc_seq`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `sdo_oe` is 0 and `sdo` is 0. `sdo` is 0 whenever `sdo_oe` is 0.
- R2: After chip-select falls, `sdo_oe` stays 0 through the first falling edge of `sclk`.
- R3: On the second falling `sclk` edge, `sdo_oe` becomes 1 and `sdo` drives a 0 null bit. The `sample` value present in that clock cycle is the word sent, and later changes to `sample` do not affect the frame.
- R4: While chip-select stays low, `sdo` and `sdo_oe` change only in the clock cycle that follows a detected falling `sclk` edge. Rising `sclk` edges and idle cycles leave them unchanged.
- R5: Falling edges 3 to 2+DATA_W send the word most significant bit first. Edge 3 carries bit DATA_W-1 and edge 2+DATA_W carries bit 0.
- R6: With `zero_fill`=0 captured, edges 3+DATA_W to 1+2*DATA_W send bits 1 through DATA_W-1 in rising order. Edge 2+2*DATA_W sets `sdo_oe` to 0.
- R7: With `zero_fill`=1 captured, every falling edge after bit 0 drives `sdo`=0 with `sdo_oe`=1 for as long as chip-select stays low.
- R8: Once `sdo_oe` has gone to 0 at the end of a mirror-mode frame, further `sclk` edges leave it at 0 while chip-select stays low.
- R9: Chip-select high forces `sdo_oe` to 0 in the next clock cycle. A frame starts only after chip-select has been observed high and then low, so chip-select held low from reset starts nothing.
- R10: `zero_fill` is taken only in the cycle where chip-select falls. Changing it during a frame has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Active-low chip-select |
| sclk | input | 1 | Serial clock; its falling edges step the frame |
| sample | input | DATA_W | Parallel result word to be latched |
| zero_fill | input | 1 | Tail mode: 0 mirrors the word, 1 drives zeros |
| sdo | output | 1 | Serial data (0 while not enabled) |
| sdo_oe | output | 1 | Output enable for the data pad |

## Verification
The bench builds the block with its default DATA_W of 12, so a mirror frame takes 26 falling edges. The last edges of that frame, where the line is released, and the edges after release fall within a 30-edge sweep. The word patterns are chosen so that bit 0, the top bit and alternating bits each differ from their neighbours. A swapped bit order, a wrong edge count or a bit repeated at the MSB/LSB seam therefore shows up as a wrong bit at a known edge number.

// File: rtl/sadc_pkg.sv
package sadc_pkg;

  // Frame phases, one per stretch of falling serial-clock edges.
  typedef enum logic [2:0] {
    PH_IDLE,   // chip-select high, or low without a fresh fall
    PH_WAIT1,  // frame armed, no falling edge yet
    PH_WAIT2,  // one falling edge seen (sampling window)
    PH_NULL,   // driving the low lead bit
    PH_MSB,    // word going out high bit first
    PH_LSB,    // word mirrored low bit first
    PH_ZERO,   // zero fill until chip-select rises
    PH_DONE    // line released, waiting for chip-select cycle
  } phase_e;

  function automatic logic phase_drives(input phase_e ph);
    return (ph == PH_NULL) || (ph == PH_MSB) || (ph == PH_LSB) || (ph == PH_ZERO);
  endfunction

  function automatic logic phase_carries_data(input phase_e ph);
    return (ph == PH_MSB) || (ph == PH_LSB);
  endfunction

endpackage

// File: rtl/sadc_edge.sv
module sadc_edge #(
  parameter logic RST_LEVEL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic sig,
  output logic fell
);

  logic sig_q;

  always_ff @(posedge clk) begin
    if (rst) sig_q <= RST_LEVEL;
    else     sig_q <= sig;
  end

  assign fell = sig_q & ~sig;

endmodule

// File: rtl/sadc_seq.sv
module sadc_seq
  import sadc_pkg::*;
#(
  parameter int DATA_W = 12,
  localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cs_n,
  input  logic             start,
  input  logic             step,
  input  logic             zero_fill,
  output phase_e           phase_d,
  output logic [IDX_W-1:0] idx_d,
  output logic             cap
);

  localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(DATA_W - 1);

  phase_e           phase_q;
  logic [IDX_W-1:0] idx_q;
  logic             fill_q;
  logic             fill_d;

  always_comb begin
    phase_d = phase_q;
    idx_d   = idx_q;
    fill_d  = fill_q;
    cap     = 1'b0;
    if (cs_n) begin
      phase_d = PH_IDLE;
    end else if (start) begin
      phase_d = PH_WAIT1;
      fill_d  = zero_fill;
    end else if (step) begin
      unique case (phase_q)
        PH_WAIT1: phase_d = PH_WAIT2;
        PH_WAIT2: begin
          phase_d = PH_NULL;
          cap     = 1'b1;
        end
        PH_NULL: begin
          phase_d = PH_MSB;
          idx_d   = TOP_IDX;
        end
        PH_MSB: begin
          if (idx_q == '0) begin
            if (fill_q) begin
              phase_d = PH_ZERO;
            end else begin
              phase_d = PH_LSB;
              idx_d   = IDX_W'(1);
            end
          end else begin
            idx_d = idx_q - IDX_W'(1);
          end
        end
        PH_LSB: begin
          if (idx_q == TOP_IDX) phase_d = PH_DONE;
          else                  idx_d   = idx_q + IDX_W'(1);
        end
        default: phase_d = phase_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      idx_q   <= '0;
      fill_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      idx_q   <= idx_d;
      fill_q  <= fill_d;
    end
  end

  // R8
  done_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_DONE && !cs_n) |=> (phase_q == PH_DONE));

  // R7
  zero_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_ZERO && !cs_n) |=> (phase_q == PH_ZERO));

  // R2
  wait_release_chk: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_WAIT1 && step && !cs_n) |=> (phase_q == PH_WAIT2));

endmodule

// File: rtl/sadc_out.sv
module sadc_out
  import sadc_pkg::*;
#(
  parameter int DATA_W = 12,
  localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cap,
  input  logic [DATA_W-1:0] sample,
  input  phase_e            phase_d,
  input  logic [IDX_W-1:0]  idx_d,
  output logic              sdo,
  output logic              sdo_oe
);

  logic [DATA_W-1:0] word_q;
  logic [DATA_W-1:0] word_nx;
  logic              sdo_nx;
  logic              oe_nx;

  always_comb begin
    word_nx = cap ? sample : word_q;
    oe_nx   = phase_drives(phase_d);
    sdo_nx  = phase_carries_data(phase_d) ? word_nx[idx_d] : 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      word_q <= '0;
      sdo    <= 1'b0;
      sdo_oe <= 1'b0;
    end else begin
      word_q <= word_nx;
      sdo    <= sdo_nx;
      sdo_oe <= oe_nx;
    end
  end

  // R3
  null_lead_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sdo_oe) |-> !sdo);

  // R1
  quiet_line_chk: assert property (@(posedge clk) disable iff (rst)
    !sdo_oe |-> !sdo);

endmodule

// File: rtl/serial_adc_seq.sv
module serial_adc_seq
  import sadc_pkg::*;
#(
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic [DATA_W-1:0] sample,
  input  logic              zero_fill,
  output logic              sdo,
  output logic              sdo_oe
);

  localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;

  logic             sclk_fall;
  logic             cs_start;
  logic             cap;
  phase_e           phase_d;
  logic [IDX_W-1:0] idx_d;

  sadc_edge #(.RST_LEVEL(1'b0)) u_sclk_edge (
    .clk (clk),
    .rst (rst),
    .sig (sclk),
    .fell(sclk_fall)
  );

  // Reset level 0 so a chip-select held low from reset is not a fall.
  sadc_edge #(.RST_LEVEL(1'b0)) u_cs_edge (
    .clk (clk),
    .rst (rst),
    .sig (cs_n),
    .fell(cs_start)
  );

  sadc_seq #(.DATA_W(DATA_W)) u_seq (
    .clk      (clk),
    .rst      (rst),
    .cs_n     (cs_n),
    .start    (cs_start),
    .step     (sclk_fall),
    .zero_fill(zero_fill),
    .phase_d  (phase_d),
    .idx_d    (idx_d),
    .cap      (cap)
  );

  sadc_out #(.DATA_W(DATA_W)) u_out (
    .clk    (clk),
    .rst    (rst),
    .cap    (cap),
    .sample (sample),
    .phase_d(phase_d),
    .idx_d  (idx_d),
    .sdo    (sdo),
    .sdo_oe (sdo_oe)
  );

  // R9
  cs_release_chk: assert property (@(posedge clk) disable iff (rst)
    cs_n |=> !sdo_oe);

  // R4
  edge_only_chk: assert property (@(posedge clk) disable iff (rst)
    (!sclk_fall && !cs_n && !cs_start) |=> ($stable(sdo) && $stable(sdo_oe)));

  // R2
  enable_on_fall_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sdo_oe) |-> $past(sclk_fall));

  // R6
  release_on_fall_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(sdo_oe) && !$past(cs_n)) |-> $past(sclk_fall));

endmodule

// File: tb/serial_adc_seq_test.sv
`timescale 1ns/1ps
module serial_adc_seq_test;

  localparam int W = 12;
  localparam int NVEC = 6;
  // {zero_fill, word}
  localparam logic [W:0] VEC [NVEC] = '{
    13'h0_A5C, 13'h1_3C1, 13'h0_FFF, 13'h0_001, 13'h1_800, 13'h0_6B9
  };

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         cs_n = 1'b1;
  logic         sclk = 1'b0;
  logic [W-1:0] sample = '0;
  logic         zero_fill = 1'b0;
  logic         sdo;
  logic         sdo_oe;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  serial_adc_seq #(.DATA_W(W)) uut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk),
    .sample(sample), .zero_fill(zero_fill), .sdo(sdo), .sdo_oe(sdo_oe)
  );

  // Expected {oe, sdo} after falling edge k of a frame.
  function automatic logic [1:0] expect_at(int k, logic [W-1:0] w, logic zf);
    if (k <= 1)        return 2'b00;
    if (k == 2)        return 2'b10;
    if (k <= 2 + W)    return {1'b1, w[W + 2 - k]};
    if (zf)            return 2'b10;
    if (k <= 1 + 2*W)  return {1'b1, w[k - W - 2]};
    return 2'b00;
  endfunction

  function automatic string tag_at(int k, logic zf);
    if (k == 1)       return "R2";
    if (k == 2)       return "R3";
    if (k <= 2 + W)   return "R5";
    if (zf)           return "R7/R10";
    if (k <= 2 + 2*W) return "R6/R10";
    return "R8";
  endfunction

  task automatic check(string req, logic [1:0] exp);
    checks++;
    if ({sdo_oe, sdo} !== exp) begin
      fails++;
      $display("FAIL %s: {oe,sdo} got %b%b expected %b%b at %0t",
               req, sdo_oe, sdo, exp[1], exp[0], $time);
    end
  endtask

  task automatic begin_frame(logic [W-1:0] w, logic zf);
    @(negedge clk) cs_n = 1'b1;
    repeat (3) @(negedge clk);
    sample = ~w; zero_fill = zf; cs_n = 1'b0;
    @(negedge clk) zero_fill = ~zf;   // R10: late change ignored
    repeat (2) @(negedge clk);
  endtask

  // One sclk pulse; checks right after the fall and again two cycles later.
  task automatic pulse(int k, logic [W-1:0] w, logic zf, logic [1:0] exp, string req);
    @(negedge clk) sclk = 1'b1;
    if (k == 2) sample = w;
    @(negedge clk) sclk = 1'b0;
    @(posedge clk) #1;
    check(req, exp);
    @(negedge clk) if (k == 2) sample = w ^ 12'hA5A;   // R3: change after capture
    @(negedge clk) sclk = 1'b1;
    @(negedge clk);
    check("R4", exp);
  endtask

  task automatic run_frame(logic [W-1:0] w, logic zf, int nfalls);
    begin_frame(w, zf);
    for (int k = 1; k <= nfalls; k++)
      pulse(k, w, zf, expect_at(k, w, zf), tag_at(k, zf));
    @(negedge clk) sclk = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: run did not end, got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    #1 check("R1", 2'b00);
    @(negedge clk) rst = 1'b0;
    @(posedge clk) #1 check("R1", 2'b00);

    // Table walk: mirror and fill frames with distinct words.
    for (int v = 0; v < NVEC; v++)
      run_frame(VEC[v][W-1:0], VEC[v][W], 30);

    // R9: abort mid-word releases the line in the next cycle.
    begin_frame(12'h5A3, 1'b0);
    for (int k = 1; k <= 8; k++)
      pulse(k, 12'h5A3, 1'b0, expect_at(k, 12'h5A3, 1'b0), tag_at(k, 1'b0));
    @(negedge clk) cs_n = 1'b1;
    @(posedge clk) #1 check("R9", 2'b00);
    @(negedge clk) sclk = 1'b0;
    // A fresh frame after the abort runs normally.
    run_frame(12'h9C6, 1'b0, 28);

    // R7: long zero fill.
    run_frame(12'hE17, 1'b1, 50);

    // R9: chip-select held low through reset starts nothing.
    @(negedge clk) begin rst = 1'b1; cs_n = 1'b0; end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    for (int k = 1; k <= 6; k++) pulse(k, 12'h3F0, 1'b0, 2'b00, "R9");
    @(negedge clk) sclk = 1'b0;

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule